// File: doc/BRIEF.md
# Uptime Seconds and Reference-Cycle Counters

This block keeps two free-running, read-only time values that start at zero when cold reset is released. A 25 MHz reference is supplied as a clock enable, `tick_en`, sampled on the block clock. A prescaler groups every sixteen enables into one step, one step every 640 ns. Each step adds sixteen to a sub-second cycle count, so the count is coarse and its four least significant bits are always zero. When the cycle count reaches 25,000,000 it goes back to zero, and on that same edge a whole-seconds count goes up by one.

Software reads both values through a small request/response port. The request channel carries an address and a write flag and uses valid/ready. A request is taken on an edge where `req_valid` and `req_ready` are both high. A read produces one response beat on the response channel, which also uses valid/ready. While a response is waiting and `rsp_ready` is low, `req_ready` stays low and the response data does not change. That is the only back-pressure path. Writes are taken and thrown away: they change nothing and produce no response.

Top module: `uptime_counters`

## Requirements
- R1: While cold reset (`rst_n` low) is asserted, and on release, the seconds count, the cycle count and the prescaler are zero, `rsp_valid` is low and `req_ready` is high.
- R2: The cycle count advances once for every 16 edges on which `tick_en` is high, whether or not those edges are consecutive. Edges with `tick_en` low are not counted.
- R3: Each advance adds exactly 16, so bits [3:0] of the cycle count always read 0.
- R4: The cycle count never reaches 25,000,000 (parameter `WRAP`). On the step taken from 24,999,984 (`WRAP`-16), it goes to 0.
- R5: The seconds count goes up by one on the same edge as that wrap, holds at every other edge, and wraps naturally at 2^32.
- R6: A read at byte address 0x068 returns the seconds count and a read at 0x06C returns the cycle count. A read of any other address returns 0.
- R7: A request with `req_write` high is accepted, produces no response, and leaves both counts unchanged.
- R8: After a read is accepted, `rsp_valid` is high on the next cycle. `rsp_data` holds the value the addressed count had just before the accepting edge, even if the count steps on that edge.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_data` and `rsp_valid` hold. A response is consumed on an edge with `rsp_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Cold reset, active low, synchronous |
| tick_en | input | 1 | One pulse per 25 MHz reference cycle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write (discarded), 0 = read |
| req_addr | input | 12 | Byte address of the request |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |

## Verification
The bench uses a reduced `WRAP` so that many seconds pass within the run. It aims at the step from `WRAP`-16 to zero: a design with an off-by-one compare would show `WRAP` itself or skip a second, and a seconds count keyed to the wrong condition would move one step early or late. Gapped enables catch a prescaler that counts clocks rather than enables. A read accepted on the very edge where the count steps catches a design that returns the post-step value. A stalled response with the counts still moving catches data that is not held under back-pressure. Writes to both addresses, followed by read-back, catch any path that lets bus data into the counts.

// File: rtl/uptime_pkg.sv
package uptime_pkg;
  // which value a read request selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_CYC  = 2'd2
  } rd_sel_e;

  localparam int unsigned DEF_CNT_W     = 32;
  localparam int unsigned DEF_ADDR_W    = 12;
  localparam int unsigned DEF_STEP_LOG2 = 4;
  localparam int unsigned DEF_WRAP      = 25_000_000;
endpackage

// File: rtl/uptime_prescaler.sv
module uptime_prescaler #(
  parameter int unsigned STEP_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic step_o
);
  generate
    if (STEP_LOG2 == 0) begin : g_direct
      assign step_o = tick_en;
    end else begin : g_count
      logic [STEP_LOG2-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else if (tick_en) pre_q <= pre_q + 1'b1;
      end
      // terminal count of the enable prescaler
      assign step_o = tick_en && (&pre_q);
    end
  endgenerate
endmodule

// File: rtl/uptime_subsec.sv
module uptime_subsec #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned STEP_LOG2 = 4,
  parameter int unsigned WRAP      = 25_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam int unsigned      STEP = 1 << STEP_LOG2;
  localparam logic [CNT_W-1:0] INC  = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRAP - STEP);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = step_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + INC;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/uptime_seconds.sv
module uptime_seconds #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sec_q <= '0;
    else if (inc_i) sec_q <= sec_q + 1'b1;
  end

  assign cnt_o = sec_q;
endmodule

// File: rtl/uptime_rdport.sv
module uptime_rdport
  import uptime_pkg::*;
#(
  parameter int unsigned        CNT_W    = 32,
  parameter int unsigned        ADDR_W   = 12,
  parameter logic [ADDR_W-1:0]  SEC_ADDR = 'h068,
  parameter logic [ADDR_W-1:0]  CYC_ADDR = 'h06C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CNT_W-1:0]  rsp_data,
  input  logic [CNT_W-1:0]  sec_i,
  input  logic [CNT_W-1:0]  cyc_i
);
  rd_sel_e          sel;
  logic [CNT_W-1:0] rd_mux;
  logic             rd_take;
  logic             vld_q;
  logic [CNT_W-1:0] dat_q;

  always_comb begin
    if (req_addr == SEC_ADDR)      sel = SEL_SEC;
    else if (req_addr == CYC_ADDR) sel = SEL_CYC;
    else                           sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_SEC: rd_mux = sec_i;
      SEL_CYC: rd_mux = cyc_i;
      default: rd_mux = '0;
    endcase
  end

  // a read may only be taken when the response slot is free or draining
  assign req_ready = !vld_q || rsp_ready;
  assign rd_take   = req_valid && !req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (req_ready) begin
      vld_q <= rd_take;
      if (rd_take) dat_q <= rd_mux;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = dat_q;
endmodule

// File: rtl/uptime_counters.sv
module uptime_counters
  import uptime_pkg::*;
#(
  parameter int unsigned        CNT_W     = DEF_CNT_W,
  parameter int unsigned        ADDR_W    = DEF_ADDR_W,
  parameter int unsigned        STEP_LOG2 = DEF_STEP_LOG2,
  parameter int unsigned        WRAP      = DEF_WRAP,
  parameter logic [ADDR_W-1:0]  SEC_ADDR  = 'h068,
  parameter logic [ADDR_W-1:0]  CYC_ADDR  = 'h06C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [CNT_W-1:0]  rsp_data
);
  logic             step;
  logic             wrap;
  logic [CNT_W-1:0] sec_val;
  logic [CNT_W-1:0] cyc_val;

  uptime_prescaler #(.STEP_LOG2(STEP_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .step_o(step)
  );

  uptime_subsec #(.CNT_W(CNT_W), .STEP_LOG2(STEP_LOG2), .WRAP(WRAP)) u_cyc (
    .clk(clk), .rst_n(rst_n), .step_i(step), .cnt_o(cyc_val), .wrap_o(wrap)
  );

  uptime_seconds #(.CNT_W(CNT_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc_i(wrap), .cnt_o(sec_val)
  );

  uptime_rdport #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SEC_ADDR(SEC_ADDR), .CYC_ADDR(CYC_ADDR)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .sec_i(sec_val), .cyc_i(cyc_val)
  );
endmodule

// File: rtl/uptime_counters_chk.sv
module uptime_counters_chk #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned STEP_LOG2 = 4,
  parameter int unsigned WRAP      = 25_000_000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] sec_val,
  input logic [CNT_W-1:0] cyc_val,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [CNT_W-1:0] rsp_data
);
  localparam logic [CNT_W-1:0] INC  = CNT_W'(1 << STEP_LOG2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRAP - (1 << STEP_LOG2));
  localparam logic [CNT_W-1:0] LIM  = CNT_W'(WRAP);

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sec_val == '0 && cyc_val == '0 && !rsp_valid));

  assert_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_val[STEP_LOG2-1:0] == '0);

  assert_below_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_val < LIM);

  assert_cyc_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_val != $past(cyc_val)) |->
      (cyc_val == $past(cyc_val) + INC || (cyc_val == '0 && $past(cyc_val) == LAST)));

  assert_sec_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_val != $past(sec_val)) |->
      (sec_val == $past(sec_val) + 1'b1 && cyc_val == '0 && $past(cyc_val) == LAST));

  assert_wrap_bumps_sec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cyc_val) == LAST && cyc_val == '0) |-> (sec_val == $past(sec_val) + 1'b1));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_stall_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind uptime_counters uptime_counters_chk #(
  .CNT_W(CNT_W), .STEP_LOG2(STEP_LOG2), .WRAP(WRAP)
) u_chk (.*);

// File: tb/sim_uptime_counters.sv
module sim_uptime_counters;
  localparam int unsigned W     = 32;
  localparam int unsigned AW    = 12;
  localparam int unsigned WRAP  = 320;   // reduced second: 20 steps
  localparam int unsigned STEPS = WRAP / 16;
  localparam logic [AW-1:0] A_SEC = 12'h068;
  localparam logic [AW-1:0] A_CYC = 12'h06C;
  localparam int NVEC = 8;
  localparam int TICK_ADD [NVEC] = '{1, 14, 1, 16, 37, 200, 51, 640};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid;
  logic [W-1:0] rsp_data;

  int total = 0;
  int bad = 0;
  int ticks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  uptime_counters #(.WRAP(WRAP)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  function automatic logic [W-1:0] m_sec(int n);
    return W'((n / 16) / STEPS);
  endfunction
  function automatic logic [W-1:0] m_cyc(int n);
    return W'(((n / 16) % STEPS) * 16);
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin @(negedge clk); tick_en = 1'b1; end
    @(negedge clk); tick_en = 1'b0;
    ticks += n;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 rsp_valid after read", W'(rsp_valid), 1);
    d = rsp_data;
  endtask

  task automatic wr(logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R7 no response to write", W'(rsp_valid), 0);
  endtask

  task automatic check_both(string tag);
    logic [W-1:0] s, c;
    rd(A_SEC, s);
    rd(A_CYC, c);
    check({tag, " R6 R5 seconds"}, s, m_sec(ticks));
    check({tag, " R6 R2 cycles"}, c, m_cyc(ticks));
    check({tag, " R3 low bits"}, W'(c[3:0]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] s, c, old, hold;
    // R1 reset state
    idle(3);
    check("R1 rsp_valid in reset", W'(rsp_valid), 0);
    check("R1 req_ready in reset", W'(req_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    check_both("R1 after release");

    // table of tick increments, one model per entry
    for (int i = 0; i < NVEC; i++) begin
      tick(TICK_ADD[i]);
      check_both("vector");
    end

    // R2 gapped enables count only enabled edges
    for (int k = 0; k < 12; k++) begin
      tick(3);
      idle(2);
    end
    check_both("R2 gapped");

    // R4 R5 wrap boundary
    tick((16 - ticks % 16) % 16);
    tick((((STEPS - 1) - (ticks / 16) % STEPS) + STEPS) % STEPS * 16);
    rd(A_CYC, c);
    check("R4 at last step", c, W'(WRAP - 16));
    rd(A_SEC, old);
    tick(15);
    rd(A_CYC, c);
    check("R4 held before step", c, W'(WRAP - 16));
    rd(A_SEC, s);
    check("R5 held before wrap", s, old);
    tick(1);
    rd(A_CYC, c);
    check("R4 wrapped to zero", c, 0);
    rd(A_SEC, s);
    check("R5 incremented on wrap", s, old + 1);

    // R7 writes discarded
    tick(48);
    wr(A_SEC);
    wr(A_CYC);
    check_both("R7 after writes");

    // R6 other addresses read zero
    rd(12'h070, c);
    check("R6 unmapped 0x070", c, 0);
    rd(12'h000, c);
    check("R6 unmapped 0x000", c, 0);

    // R8 read accepted on the stepping edge returns pre-step value
    tick((15 - ticks % 16 + 16) % 16);
    old = m_cyc(ticks);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = A_CYC; tick_en = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; tick_en = 1'b0; ticks += 1;
    check("R8 snapshot before step", rsp_data, old);
    check_both("R8 after step");

    // R9 back-pressure while counts keep moving
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_write = 1'b0; req_addr = A_CYC;
    @(negedge clk);
    req_addr = A_SEC;  // stays pending, must not be taken
    hold = rsp_data;
    check("R9 stalled valid", W'(rsp_valid), 1);
    tick_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check("R9 req_ready low", W'(req_ready), 0);
      check("R9 data held", rsp_data, hold);
    end
    tick_en = 1'b0; ticks += 20;
    req_valid = 1'b0;
    check("R9 stalled data value", hold, m_cyc(ticks - 20));
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R9 consumed", W'(rsp_valid), 0);
    check_both("R9 after stall");

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    check("R1 rsp_valid mid reset", W'(rsp_valid), 0);
    rst_n = 1'b1; ticks = 0;
    check_both("R1 mid-run reset");
    tick(15);
    check_both("R1 prescaler cleared");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule